// File: doc/BRIEF.md
# SRAM Entropy Address Mapper and Conditioner

This block turns the power-up contents of an external 64K x 32 SRAM into two kinds of data: physically unclonable function (PUF) response words and random-number words. The SRAM is split into two regions. The lowest 256 words are used only for random data, and the remaining 65,280 words are used only for PUF data. A single request picks one of the two uses. A PUF request carries a 12-bit challenge, which selects a block of 32 consecutive words. A random request carries a word offset inside the random region. The block then issues 32 SRAM reads, one per cycle, and conditions each returned word by XOR folding. PUF data keeps half of the raw bits. Random data keeps one eighth of them.

Conditioned data leaves on a valid/ready stream. A PUF request yields eight 64-bit words in the low half of the output bus. A random request yields one 128-bit word. A request that would leave its region is refused: a reject pulse is raised and no SRAM read is made.

The controller is a four-state machine:
- IDLE: accepts a request. It moves to REJECT for an out-of-range argument, otherwise to READ.
- REJECT: lasts one cycle, then returns to IDLE.
- READ: issues reads. It moves to DRAIN when the 32nd read is issued.
- DRAIN: waits for the last output word to be handed over, then returns to IDLE.

Top module: `sram_entropy_mapper`

## Requirements
- R1: After reset, `req_ready`=1, and `busy`, `out_valid`, `sram_re` and `req_reject` are all 0.
- R2: A PUF request (`req_mode`=0) with challenge y < 2040 reads addresses y*32+256 through y*32+287 in ascending order, once each, one per cycle while not stalled.
- R3: A PUF challenge of 2040 or more, or a random offset above 224, is refused. `req_reject` is high for exactly the one cycle after acceptance. `busy` stays 0, no SRAM read is issued and no output word is produced.
- R4: PUF conditioning works as follows. Each read word w contributes 16 bits: bits [7:0] = w[7:0]^w[15:8] and bits [15:8] = w[23:16]^w[31:24]. Four consecutive reads are packed LSB first into `out_data[63:0]`, with `out_data[127:64]`=0. Eight words are produced per request, and `out_last` is set on the eighth.
- R5: A random request (`req_mode`=1) with offset o ≤ 224 reads addresses o through o+31 in order. A random read address is always below 256, and a PUF read address is always 256 or above.
- R6: Random conditioning works as follows. Byte j of the single 128-bit output word is the XOR of all eight bytes of reads 2j and 2j+1 of the request. `out_last` is set on this word.
- R7: With `out_ready` held high, the k-th PUF word (k=0..7) is valid 5+4k cycles after the accepting edge, and the random word is valid 33 cycles after it.
- R8: While `out_valid`=1 and `out_ready`=0, no SRAM read is issued, `out_data` holds its value and no conditioned data is lost.
- R9: `busy` is high from the accepting edge until the edge on which the last word is handed over. `req_ready` is high only in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (IDLE) |
| req_mode | input | 1 | 0 = PUF challenge, 1 = random offset |
| req_arg | input | 12 | Challenge or word offset |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | Request in progress |
| sram_re | output | 1 | SRAM read enable |
| sram_addr | output | 16 | SRAM word address |
| sram_rdata | input | 32 | SRAM read data, one cycle after `sram_re` |
| out_valid | output | 1 | Conditioned word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 128 | Conditioned word |
| out_last | output | 1 | Final word of the request |

## Verification
Each request is timed from its accepting edge. Read k of a request appears in cycle k after that edge, and its data returns one edge later. A PUF word is therefore due 5+4k edges after acceptance and the random word 33 edges after it, and the bench counts edges against exactly these numbers while `out_ready` is held high. Under random backpressure, data words are checked only on handshake cycles, and a stalled word is compared one cycle later against the value it held. The reject pulse is sampled on the first cycle after acceptance. Address checks run on the falling edge, in the middle of the cycle in which each read is issued.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REJECT = 2'd1,
        ST_READ   = 2'd2,
        ST_DRAIN  = 2'd3
    } sem_state_t;

    typedef enum logic {
        MODE_PUF = 1'b0,
        MODE_RNG = 1'b1
    } sem_mode_t;

endpackage

// File: rtl/sem_addr_map.sv
module sem_addr_map
    import sem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ARG_W     = 12,
    parameter int RNG_WORDS = 256,
    parameter int BLK_WORDS = 32,
    parameter int PUF_SLOTS = 2040
) (
    input  sem_mode_t          mode,
    input  logic [ARG_W-1:0]   arg,
    output logic [ADDR_W-1:0]  base,
    output logic               reject
);
    localparam int BLK_SH  = $clog2(BLK_WORDS);
    localparam int RNG_MAX = RNG_WORDS - BLK_WORDS;

    logic [ADDR_W-1:0] puf_base;
    logic [ADDR_W-1:0] rng_base;
    logic              puf_bad;
    logic              rng_bad;

    always_comb begin
        puf_base = (ADDR_W'(arg) << BLK_SH) + ADDR_W'(RNG_WORDS);
        rng_base = ADDR_W'(arg);
        puf_bad  = (int'(arg) >= PUF_SLOTS);
        rng_bad  = (int'(arg) > RNG_MAX);
    end

    always_comb begin
        if (mode == MODE_PUF) begin
            base   = puf_base;
            reject = puf_bad;
        end else begin
            base   = rng_base;
            reject = rng_bad;
        end
    end

endmodule

// File: rtl/sem_fold.sv
module sem_fold #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]   word,
    output logic [WORD_W/2-1:0] puf_chunk,
    output logic [7:0]          rng_byte
);
    localparam int NBYTES = WORD_W / 8;
    localparam int NPAIRS = NBYTES / 2;

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        assign puf_chunk[8*p +: 8] = word[16*p +: 8] ^ word[16*p + 8 +: 8];
    end

    always_comb begin
        rng_byte = '0;
        for (int b = 0; b < NBYTES; b++) begin
            rng_byte = rng_byte ^ word[8*b +: 8];
        end
    end

endmodule

// File: rtl/sem_pack.sv
module sem_pack
    import sem_pkg::*;
#(
    parameter int CHUNK_W   = 16,
    parameter int PUF_OUT_W = 64,
    parameter int BLK_WORDS = 32,
    parameter int OUT_W     = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  sem_mode_t                    mode,
    input  logic [$clog2(BLK_WORDS)-1:0] rx_idx,
    input  logic [CHUNK_W-1:0]           puf_chunk,
    input  logic [7:0]                   rng_byte,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [OUT_W-1:0]             out_data,
    output logic                         out_last
);
    localparam int IDX_W     = $clog2(BLK_WORDS);
    localparam int PER_WORD  = PUF_OUT_W / CHUNK_W;
    localparam int LANE_W    = $clog2(PER_WORD);

    logic [OUT_W-1:0]  acc;
    logic [OUT_W-1:0]  acc_next;
    logic [7:0]        part;
    logic [LANE_W-1:0] lane;
    logic [IDX_W-2:0]  byte_ix;
    logic              odd;
    logic              final_rx;
    logic              complete;

    always_comb begin
        lane     = rx_idx[LANE_W-1:0];
        byte_ix  = rx_idx[IDX_W-1:1];
        odd      = rx_idx[0];
        final_rx = (rx_idx == IDX_W'(BLK_WORDS - 1));
        if (mode == MODE_PUF) begin
            complete = (lane == LANE_W'(PER_WORD - 1));
        end else begin
            complete = final_rx;
        end
    end

    always_comb begin
        acc_next = acc;
        if (mode == MODE_PUF) begin
            acc_next[int'(lane)*CHUNK_W +: CHUNK_W] = puf_chunk;
        end else if (odd) begin
            acc_next[int'(byte_ix)*8 +: 8] = part ^ rng_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            part <= '0;
        end else if (in_valid) begin
            if (mode == MODE_RNG && !odd) begin
                part <= rng_byte;
            end
            if (complete) begin
                acc <= '0;
            end else begin
                acc <= acc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (in_valid && complete) begin
            out_valid <= 1'b1;
            out_data  <= acc_next;
            out_last  <= final_rx;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && complete) |-> !(out_valid && !out_ready));

    // R4
    puf_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && complete && mode == MODE_PUF) |=> (out_data[OUT_W-1:PUF_OUT_W] == '0));

endmodule

// File: rtl/sram_entropy_mapper.sv
module sram_entropy_mapper
    import sem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int ARG_W     = 12,
    parameter int RNG_WORDS = 256,
    parameter int BLK_WORDS = 32,
    parameter int PUF_SLOTS = 2040,
    parameter int PUF_OUT_W = 64,
    parameter int OUT_W     = (BLK_WORDS / 2) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_mode,
    input  logic [ARG_W-1:0]  req_arg,
    output logic              req_reject,
    output logic              busy,
    output logic              sram_re,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [WORD_W-1:0] sram_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_last
);
    localparam int IDX_W   = $clog2(BLK_WORDS);
    localparam int CHUNK_W = WORD_W / 2;

    sem_state_t        state_q, state_d;
    sem_mode_t         req_mode_e;
    sem_mode_t         mode_q;
    logic [ADDR_W-1:0] map_base;
    logic              map_reject;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  rd_cnt;
    logic [IDX_W-1:0]  rx_cnt;
    logic              rd_pend;
    logic              accept;
    logic              issue;
    logic              stalled;
    logic              last_rd;
    logic              last_out;
    logic [CHUNK_W-1:0] puf_chunk;
    logic [7:0]        rng_byte;

    assign req_mode_e = sem_mode_t'(req_mode);

    sem_addr_map #(
        .ADDR_W(ADDR_W), .ARG_W(ARG_W), .RNG_WORDS(RNG_WORDS),
        .BLK_WORDS(BLK_WORDS), .PUF_SLOTS(PUF_SLOTS)
    ) map_i (
        .mode(req_mode_e), .arg(req_arg), .base(map_base), .reject(map_reject)
    );

    sem_fold #(.WORD_W(WORD_W)) fold_i (
        .word(sram_rdata), .puf_chunk(puf_chunk), .rng_byte(rng_byte)
    );

    sem_pack #(
        .CHUNK_W(CHUNK_W), .PUF_OUT_W(PUF_OUT_W),
        .BLK_WORDS(BLK_WORDS), .OUT_W(OUT_W)
    ) pack_i (
        .clk(clk), .rst_n(rst_n), .in_valid(rd_pend), .mode(mode_q),
        .rx_idx(rx_cnt), .puf_chunk(puf_chunk), .rng_byte(rng_byte),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        stalled  = out_valid && !out_ready;
        issue    = (state_q == ST_READ) && !stalled;
        last_rd  = (rd_cnt == IDX_W'(BLK_WORDS - 1));
        last_out = out_valid && out_ready && out_last;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = map_reject ? ST_REJECT : ST_READ;
                end
            end
            ST_REJECT: state_d = ST_IDLE;
            ST_READ: begin
                if (issue && last_rd) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (last_out) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        req_ready  = 1'b0;
        req_reject = 1'b0;
        busy       = 1'b0;
        sram_re    = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready  = 1'b1;
            ST_REJECT: req_reject = 1'b1;
            ST_READ: begin
                busy    = 1'b1;
                sram_re = issue;
            end
            ST_DRAIN:  busy = 1'b1;
            default: ;
        endcase
    end

    // request capture and read counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_PUF;
            base_q  <= '0;
            rd_cnt  <= '0;
            rx_cnt  <= '0;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= issue;
            if (accept) begin
                mode_q <= req_mode_e;
                base_q <= map_base;
                rd_cnt <= '0;
                rx_cnt <= '0;
            end else begin
                if (issue) begin
                    rd_cnt <= rd_cnt + 1'b1;
                end
                if (rd_pend) begin
                    rx_cnt <= rx_cnt + 1'b1;
                end
            end
        end
    end

    assign sram_addr = base_q + ADDR_W'(rd_cnt);

    // R5
    rng_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_re && mode_q == MODE_RNG) |-> (int'(sram_addr) < RNG_WORDS));

    // R5
    puf_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_re && mode_q == MODE_PUF) |-> (int'(sram_addr) >= RNG_WORDS));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_re && $past(sram_re)) |-> (sram_addr == $past(sram_addr) + 1'b1));

    // R8
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !sram_re);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (!busy && !sram_re && !out_valid));

    // R3
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |=> !req_reject);

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

endmodule

// File: tb/sram_entropy_mapper_tb.sv
module sram_entropy_mapper_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_mode = 1'b0;
    logic [11:0]  req_arg = '0;
    logic         req_reject;
    logic         busy;
    logic         sram_re;
    logic [15:0]  sram_addr;
    logic [31:0]  sram_rdata = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic         out_last;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    int    exp_base = 0;
    int    rd_seen = 0;
    string mon_tag = "R2";
    int    hs_t[8];

    always #2.5 clk = ~clk;

    sram_entropy_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_arg(req_arg), .req_reject(req_reject),
        .busy(busy), .sram_re(sram_re), .sram_addr(sram_addr),
        .sram_rdata(sram_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        logic [31:0] x;
        x = {a, ~a} * 32'h9E37_79B1;
        return x ^ (x >> 15);
    endfunction

    function automatic logic [127:0] exp_puf(input int base, input int w);
        logic [127:0] v = '0;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] r;
            r = mem_word(16'(base + 4*w + k));
            v[16*k +: 8]     = r[7:0] ^ r[15:8];
            v[16*k + 8 +: 8] = r[23:16] ^ r[31:24];
        end
        return v;
    endfunction

    function automatic logic [127:0] exp_rng(input int base);
        logic [127:0] v = '0;
        for (int j = 0; j < 16; j++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = mem_word(16'(base + 2*j));
            b = mem_word(16'(base + 2*j + 1));
            v[8*j +: 8] = a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24]
                        ^ b[7:0] ^ b[15:8] ^ b[23:16] ^ b[31:24];
        end
        return v;
    endfunction

    // synchronous SRAM model, one cycle read latency
    always @(posedge clk) begin
        if (sram_re) sram_rdata <= mem_word(sram_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // address monitor, mid-cycle
    always @(negedge clk) begin
        if (rst_n && sram_re) begin
            chk(sram_addr == 16'(exp_base + rd_seen), mon_tag, "read address",
                128'(sram_addr), 128'(exp_base + rd_seen));
            rd_seen++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_req(input bit mode, input int arg, input int rdy_pct, input bit want_rej);
        int n;
        int idx;
        int t;
        bit stall_prev;
        logic [127:0] held;
        string dtag;
        exp_base = mode ? arg : arg*32 + 256;
        rd_seen  = 0;
        mon_tag  = mode ? "R5" : "R2";
        dtag     = mode ? "R6" : "R4";
        req_valid = 1'b1;
        req_mode  = mode;
        req_arg   = 12'(arg);
        out_ready = 1'b0;
        while (!req_ready) tick();
        tick();
        req_valid = 1'b0;
        if (want_rej) begin
            chk(req_reject === 1'b1, "R3", "reject pulse", 128'(req_reject), 128'(1));
            chk(busy === 1'b0, "R3", "busy on reject", 128'(busy), 128'(0));
            for (int i = 0; i < 6; i++) begin
                tick();
                if (i == 0) chk(req_reject === 1'b0, "R3", "reject width", 128'(req_reject), 128'(0));
                chk(out_valid === 1'b0, "R3", "no output", 128'(out_valid), 128'(0));
            end
            chk(rd_seen == 0, "R3", "no reads", 128'(rd_seen), 128'(0));
            chk(req_ready === 1'b1, "R3", "ready again", 128'(req_ready), 128'(1));
            return;
        end
        chk(busy === 1'b1 && req_reject === 1'b0, "R9", "busy after accept", 128'(busy), 128'(1));
        n = mode ? 1 : 8;
        idx = 0;
        t = 0;
        stall_prev = 0;
        held = '0;
        while (idx < n && t < 3000) begin
            out_ready = ($urandom_range(0, 99) < rdy_pct);
            if (stall_prev)
                chk(out_valid === 1'b1 && out_data == held, "R8", "held word", out_data, held);
            stall_prev = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                chk(out_data == (mode ? exp_rng(exp_base) : exp_puf(exp_base, idx)),
                    dtag, "data word", out_data,
                    mode ? exp_rng(exp_base) : exp_puf(exp_base, idx));
                chk(out_last == (idx == n - 1), dtag, "last flag", 128'(out_last), 128'(idx == n - 1));
                hs_t[idx] = t;
                idx++;
            end
            tick();
            t++;
        end
        if (t >= 3000) chk(1'b0, "R9", "request timeout", 128'(idx), 128'(n));
        out_ready = 1'b0;
        chk(busy === 1'b0 && req_ready === 1'b1, "R9", "idle after last", 128'(busy), 128'(0));
        chk(rd_seen == 32, mon_tag, "read count", 128'(rd_seen), 128'(32));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) tick();
        // R1 reset state
        chk(req_ready === 1'b1 && busy === 1'b0, "R1", "ready/busy in reset", {busy, req_ready}, 128'(1));
        chk(out_valid === 1'b0 && sram_re === 1'b0 && req_reject === 1'b0, "R1", "outputs in reset",
            {out_valid, sram_re, req_reject}, 128'(0));
        rst_n = 1'b1;
        tick();
        chk(req_ready === 1'b1 && busy === 1'b0 && out_valid === 1'b0, "R1", "idle after reset",
            {req_ready, busy, out_valid}, 128'(4));

        // R7 latency, PUF, ready held high
        run_req(1'b0, 5, 100, 1'b0);
        for (int k = 0; k < 8; k++)
            chk(hs_t[k] == 5 + 4*k, "R7", "puf word timing", 128'(hs_t[k]), 128'(5 + 4*k));
        // R7 latency, random word
        run_req(1'b1, 0, 100, 1'b0);
        chk(hs_t[0] == 33, "R7", "rng word timing", 128'(hs_t[0]), 128'(33));

        // boundaries: top PUF block and top random window
        run_req(1'b0, 2039, 100, 1'b0);
        run_req(1'b1, 224, 60, 1'b0);
        // R3 refused arguments
        run_req(1'b0, 2040, 100, 1'b1);
        run_req(1'b0, 4095, 100, 1'b1);
        run_req(1'b1, 225, 100, 1'b1);
        run_req(1'b0, 0, 30, 1'b0);

        // random mix with backpressure
        for (int i = 0; i < 14; i++) begin
            bit m;
            int a;
            int pct;
            m   = $urandom_range(0, 1) == 1;
            a   = m ? $urandom_range(0, 240) : $urandom_range(0, 2100);
            pct = $urandom_range(20, 100);
            run_req(m, a, pct, m ? (a > 224) : (a >= 2040));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule